// File: doc/BRIEF.md
# Self-Clearing Command Byte with Counter and Probe Actions

This block holds a write-only command byte for a small incremental counting subsystem. A single write carries several requests at once. The low five bits are one-shot requests. Any of them written as 1 raises a matching action pulse for exactly one clock and then falls back to 0 with no further write. The two bits above them are actuator levels that stay at the value last written. The top bit is unused.

The pulses act on parts that sit inside the block, so their effect can be observed:
- Three free-running counters advance on external increment enables. Each one is cleared by its own request bit.
- A two-stage touch-probe chain shifts on the capture request. The first stage takes counter 0 and the second stage takes the old first stage.
- The zero-codification request is passed out as a pulse for the logic that uses it.

The capture chain is built only when the counter width is 24 bits. Quadrature decoding and bus address decoding are outside the block. The bus delivers a write strobe and a data byte that have already been qualified by address.

Top module: `instr_strobe_reg`

## Requirements
- R1: After reset, the pulse outputs, all counters, both probe stages and both actuator outputs are 0.
- R2: A write with bit n = 1 (n in 0..4) drives pulse_o[n] high for exactly the one cycle after the write edge. The pulse then returns to 0 unless another write sets bit n again.
- R3: Writing 0 to a request bit, or holding wr_en low, produces no pulse and leaves the counters and probe stages unchanged.
- R4: A pulse on pulse_o[n] (n in 0..2) clears counter n at the next edge. The clear wins over an increment in that same cycle.
- R5: Counter n increases by one at every clock edge where inc_i[n] is 1 and no clear is active.
- R6: A pulse on pulse_o[4] loads tp2_o with the old tp1_o and tp1_o with counter 0's value, both at the same edge.
- R7: A single write with bit 0 and bit 4 both set loads tp1_o with counter 0's value from before the clear.
- R8: Bits 5 and 6 of a write set act_o[0] and act_o[1] (0 is low, 1 is high). These levels hold until the next write.
- R9: Bit 3 written as 1 produces a one-cycle pulse on pulse_o[3], the zero-codification enable request.
- R10: Bit 7 of the written byte has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command byte |
| wr_data | input | 8 | Command byte |
| inc_i | input | 3 | Increment enable for each counter |
| pulse_o | output | 5 | One-cycle action pulses: counter 0..2 clears, zero-codification enable, probe capture |
| cnt_o | output | 3*CNT_W | Counter values, counter n in slice n |
| tp1_o | output | CNT_W | First probe capture stage |
| tp2_o | output | CNT_W | Second probe capture stage |
| act_o | output | 2 | Actuator levels |

## Verification
A counter clear and a probe capture can land on the same edge, because one write can set bit 0 and bit 4 together. The bench writes such a combined byte while counter 0 is running, and then compares the first probe stage against the count it expected before the clear. It also issues capture requests back to back so that both probe stages shift on consecutive edges. The increment enables stay active while clear pulses arrive, which checks that the clear wins over the count.

// File: rtl/instr_strobe_reg.sv
module instr_strobe_reg #(
  parameter int CNT_W = 24,
  parameter int N_CNT = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_data,
  input  logic [N_CNT-1:0]            inc_i,
  output logic [4:0]                  pulse_o,
  output logic [N_CNT-1:0][CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0]            tp1_o,
  output logic [CNT_W-1:0]            tp2_o,
  output logic [1:0]                  act_o
);

  localparam int NUM_STRB = 5;
  localparam int TP_BIT   = 4;

  logic [NUM_STRB-1:0] strb_q;
  logic [1:0]          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      act_q  <= '0;
    end else begin
      strb_q <= wr_en ? wr_data[NUM_STRB-1:0] : '0;
      if (wr_en) act_q <= wr_data[6:5];
    end
  end

  assign pulse_o = strb_q;
  assign act_o   = act_q;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (strb_q[g]) cnt_q <= '0;
      else if (inc_i[g])  cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o[g] |=> (cnt_o[g] == '0));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_o[g] && inc_i[g]) |=> (cnt_o[g] == $past(cnt_o[g]) + 1'b1));
  end

  if (CNT_W == 24) begin : g_tp
    logic [CNT_W-1:0] tp1_q, tp2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tp1_q <= '0;
        tp2_q <= '0;
      end else if (strb_q[TP_BIT]) begin
        tp2_q <= tp1_q;
        tp1_q <= cnt_o[0];
      end
    end
    assign tp1_o = tp1_q;
    assign tp2_o = tp2_q;

    // R6 R7
    tp_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o[TP_BIT] |=> (tp1_o == $past(cnt_o[0]) && tp2_o == $past(tp1_o)));

    // R3
    tp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_o[TP_BIT] |=> ($stable(tp1_o) && $stable(tp2_o)));
  end else begin : g_no_tp
    assign tp1_o = '0;
    assign tp2_o = '0;
  end

  // R2 R3
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (pulse_o == '0));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(act_o));

  // R8
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (act_o == $past(wr_data[6:5])));

endmodule

// File: tb/instr_strobe_reg_tb.sv
`timescale 1ns/1ps
module instr_strobe_reg_tb_top;
  localparam int W = 24;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] inc_i = '0;
  logic [4:0] pulse_o;
  logic [2:0][W-1:0] cnt_o;
  logic [W-1:0] tp1_o, tp2_o;
  logic [1:0] act_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  instr_strobe_reg #(.CNT_W(W), .N_CNT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .inc_i(inc_i),
    .pulse_o(pulse_o), .cnt_o(cnt_o), .tp1_o(tp1_o), .tp2_o(tp2_o), .act_o(act_o));

  typedef struct {
    logic [4:0] pulse;
    logic [2:0][W-1:0] cnt;
    logic [W-1:0] tp1, tp2;
    logic [1:0] act;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  logic [4:0] m_pulse = '0;
  logic [2:0][W-1:0] m_cnt = '0;
  logic [W-1:0] m_tp1 = '0, m_tp2 = '0;
  logic [1:0] m_act = '0;

  task automatic check(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] inc, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; inc_i = inc;
    for (int i = 0; i < 3; i++) e.cnt[i] = m_pulse[i] ? '0 : m_cnt[i] + W'(inc[i]);
    e.tp1 = m_pulse[4] ? m_cnt[0] : m_tp1;
    e.tp2 = m_pulse[4] ? m_tp1 : m_tp2;
    e.pulse = w ? d[4:0] : 5'd0;
    e.act = w ? d[6:5] : m_act;
    e.tag = tag;
    m_pulse = e.pulse; m_cnt = e.cnt; m_tp1 = e.tp1; m_tp2 = e.tp2; m_act = e.act;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "pulse", W'(pulse_o), W'(e.pulse));
        for (int i = 0; i < 3; i++) check(e.tag, "cnt", cnt_o[i], e.cnt[i]);
        check(e.tag, "tp1", tp1_o, e.tp1);
        check(e.tag, "tp2", tp2_o, e.tp2);
        check(e.tag, "act", W'(act_o), W'(e.act));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pulse", W'(pulse_o), '0);
    check("R1", "cnt0", cnt_o[0], '0);
    check("R1", "tp1", tp1_o, '0);
    check("R1", "tp2", tp2_o, '0);
    check("R1", "act", W'(act_o), '0);
    rst_n = 1;
    for (int k = 0; k < 10; k++) step(0, 8'h00, 3'b111, "R5");
    step(1, 8'h01, 3'b111, "R4");
    step(0, 8'h00, 3'b111, "R4");
    step(1, 8'h02, 3'b011, "R4");
    step(0, 8'h00, 3'b010, "R4");
    step(1, 8'h04, 3'b100, "R4");
    step(0, 8'h00, 3'b111, "R2");
    step(1, 8'h08, 3'b111, "R9");
    step(0, 8'h00, 3'b111, "R9");
    step(0, 8'h00, 3'b101, "R5");
    step(1, 8'h10, 3'b111, "R6");
    step(0, 8'h00, 3'b111, "R6");
    step(0, 8'h00, 3'b111, "R6");
    step(1, 8'h10, 3'b111, "R6");
    step(1, 8'h10, 3'b111, "R6");
    step(0, 8'h00, 3'b111, "R6");
    for (int k = 0; k < 4; k++) step(0, 8'h00, 3'b001, "R5");
    step(1, 8'h11, 3'b111, "R7");
    step(0, 8'h00, 3'b111, "R7");
    step(0, 8'h00, 3'b111, "R7");
    step(1, 8'h60, 3'b000, "R8");
    step(0, 8'h00, 3'b000, "R8");
    step(1, 8'h20, 3'b000, "R8");
    step(0, 8'h00, 3'b111, "R8");
    step(1, 8'h40, 3'b111, "R8");
    step(1, 8'hC0, 3'b111, "R10");
    step(0, 8'h00, 3'b111, "R10");
    step(1, 8'h80, 3'b111, "R10");
    step(0, 8'h00, 3'b111, "R10");
    step(1, 8'h00, 3'b111, "R3");
    step(0, 8'h1F, 3'b111, "R3");
    step(0, 8'h00, 3'b111, "R3");
    step(1, 8'h1F, 3'b000, "R2");
    step(0, 8'h00, 3'b000, "R2");
    step(0, 8'h00, 3'b000, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule